// File: doc/BRIEF.md
# Clock-to-signal edge skew meter

This block watches two single-bit inputs, a reference clock and a response signal, both sampled on a fast sampling clock. Each sampling edge is one sample. For every active reference edge it measures the number of samples until the next active response edge and reports that count with a one-cycle valid strobe. It is meant for measuring the delay and jitter between a clock and a signal derived from it, with the raw sample count handed to later logic.

Each input has its own polarity select, so the active edge can be rising, falling or either. The core is a two-state pairing machine: it waits for a reference edge, then it waits for a response edge. Both steps can happen within one sample. A reference edge that arrives while a response is still outstanding is counted as a missed reference. A response edge that arrives while no reference is pending is counted as a missed response. Both miss counters saturate, and each miss also gives a one-cycle event pulse. If the measured interval is longer than the sample counter can represent, an overflow bit goes out with the measurement.

Top module: `skew_meter`

## Requirements
- R1: While `rst_i` is high at a sampling edge, all outputs clear to zero, the sample index clears to 0 and the machine returns to waiting for a reference edge.
- R2: Polarity selects are encoded as 0 = rising (previous 0, current 1), 1 = falling (previous 1, current 0), 2 or 3 = either transition. Each input uses its own select, and the select is applied on the sample being evaluated.
- R3: The first sample after reset only records the input levels. It detects no edge on either input, whatever those levels are.
- R4: When a response edge completes a pairing, `delta_o` takes the response sample index minus the latched reference sample index, modulo 2^CNT_W, and `delta_valid_o` is high for exactly the one cycle after that sampling edge.
- R5: An active reference edge and an active response edge in the same sample, while waiting for a reference, produce a measurement of 0 and no miss event.
- R6: A reference edge while waiting for a response increments the missed-reference counter and pulses `miss_ref_pulse_o`. The latched reference index is not changed, so the later measurement still starts from the first reference edge.
- R7: A response edge while waiting for a reference increments the missed-response counter and pulses `miss_rsp_pulse_o`. This happens only after at least one measurement has completed since reset.
- R8: While waiting for a response, an active response edge and an active reference edge in the same sample complete the measurement and latch the new reference in that sample, with no miss event.
- R9: Both miss counters are MISS_W bits wide and stop at their all-ones value. Each miss still pulses its flag when the counter is saturated.
- R10: `delta_ovf_o` is high with a measurement whose true interval is at least 2^CNT_W samples, and low otherwise.
- R11: Between measurements, `delta_o` and `delta_ovf_o` keep the value of the last measurement.
- R12: `delta_valid_o` is never high in the same cycle as either miss pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock; each rising edge is one sample |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_i | input | 1 | Reference clock being measured |
| rsp_i | input | 1 | Response signal being measured |
| ref_pol_i | input | 2 | Active-edge select for the reference input |
| rsp_pol_i | input | 2 | Active-edge select for the response input |
| delta_o | output | CNT_W | Last measured reference-to-response interval in samples |
| delta_valid_o | output | 1 | One-cycle strobe marking a new measurement |
| delta_ovf_o | output | 1 | Interval of the last measurement exceeded the counter range |
| miss_ref_pulse_o | output | 1 | One-cycle pulse for a reference edge with no matching response |
| miss_rsp_pulse_o | output | 1 | One-cycle pulse for a response edge with no pending reference |
| miss_ref_cnt_o | output | MISS_W | Saturating count of missed reference edges |
| miss_rsp_cnt_o | output | MISS_W | Saturating count of missed response edges |

## Verification
The bench targets coincident edges, both while waiting for a reference and while waiting for a response. A machine that takes only one step per sample would report a measurement of one instead of zero, or would book a spurious miss and lose the new reference. It also tests a response edge that comes before any measurement, which a design without a first-response guard would count as a miss, and an input held high through reset, which would otherwise show up as a false edge on the first sample. Long gaps of exactly 2^CNT_W and slightly more samples, together with a run of misses past the counter limit, expose a wrong overflow point or a counter that wraps.

// File: rtl/skew_pkg.sv
package skew_pkg;

    typedef enum logic {
        ST_WAIT_REF = 1'b0,
        ST_WAIT_RSP = 1'b1
    } meas_st_e;

    typedef enum logic [1:0] {
        POL_RISE = 2'd0,
        POL_FALL = 2'd1,
        POL_ANY  = 2'd2
    } edge_pol_e;

    // Edge qualifier: previous level, current level, polarity select.
    function automatic logic pol_match(logic prev, logic cur, logic [1:0] pol);
        logic hit;
        if (pol == POL_RISE) begin
            hit = !prev && cur;
        end else if (pol == POL_FALL) begin
            hit = prev && !cur;
        end else begin
            hit = prev ^ cur;
        end
        return hit;
    endfunction

endpackage

// File: rtl/skew_edge_detect.sv
module skew_edge_detect
    import skew_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       primed_i,
    input  logic       sig_i,
    input  logic [1:0] pol_i,
    output logic       edge_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        edge_o = primed_i && pol_match(prev_q, sig_i, pol_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    // R2: a qualified edge always needs a level change against the held sample
    assert_edge_needs_change_R2: assert property (
        @(posedge clk_i) disable iff (rst_i)
        edge_o |-> (sig_i != prev_q)
    );

endmodule

// File: rtl/skew_sat_counter.sv
module skew_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         pulse_o
);

    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pulse;
    } cnt_s;

    cnt_s cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.pulse = inc_i;
        if (inc_i && (cur_q.cnt != MAX_VAL)) begin
            nxt_d.cnt = cur_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cnt_o   = cur_q.cnt;
    assign pulse_o = cur_q.pulse;

    // R9: once saturated the count stays at the ceiling
    assert_sat_hold_R9: assert property (
        @(posedge clk_i) disable iff (rst_i)
        (cnt_o == MAX_VAL) |=> (cnt_o == MAX_VAL)
    );

    // R9: a pulse steps the count by one unless already at the ceiling
    assert_pulse_steps_R9: assert property (
        @(posedge clk_i) disable iff (rst_i)
        pulse_o |-> ((cnt_o == $past(cnt_o) + W'(1)) ||
                     (($past(cnt_o) == MAX_VAL) && (cnt_o == MAX_VAL)))
    );

    // R9: the count does not move without an event pulse
    assert_quiet_hold_R9: assert property (
        @(posedge clk_i) disable iff (rst_i)
        !pulse_o |-> $stable(cnt_o)
    );

endmodule

// File: rtl/skew_meter.sv
module skew_meter
    import skew_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int MISS_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ref_i,
    input  logic              rsp_i,
    input  logic [1:0]        ref_pol_i,
    input  logic [1:0]        rsp_pol_i,
    output logic [CNT_W-1:0]  delta_o,
    output logic              delta_valid_o,
    output logic              delta_ovf_o,
    output logic              miss_ref_pulse_o,
    output logic              miss_rsp_pulse_o,
    output logic [MISS_W-1:0] miss_ref_cnt_o,
    output logic [MISS_W-1:0] miss_rsp_cnt_o
);

    localparam int NCH    = 2;
    localparam int CH_REF = 0;
    localparam int CH_RSP = 1;

    typedef struct packed {
        meas_st_e         st;
        logic             primed;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] ref_idx;
        logic             wrap;
        logic             have_rsp;
        logic [CNT_W-1:0] delta;
        logic             vld;
        logic             ovf;
    } meter_s;

    meter_s cur_q, nxt_d;

    logic [NCH-1:0]             smp;
    logic [NCH-1:0][1:0]        pol;
    logic [NCH-1:0]             edg;
    logic [NCH-1:0]             miss_inc;
    logic [NCH-1:0][MISS_W-1:0] miss_cnt;
    logic [NCH-1:0]             miss_pulse;

    assign smp[CH_REF] = ref_i;
    assign smp[CH_RSP] = rsp_i;
    assign pol[CH_REF] = ref_pol_i;
    assign pol[CH_RSP] = rsp_pol_i;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        skew_edge_detect u_edge (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .primed_i (cur_q.primed),
            .sig_i    (smp[g]),
            .pol_i    (pol[g]),
            .edge_o   (edg[g])
        );

        skew_sat_counter #(
            .W (MISS_W)
        ) u_miss (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .inc_i   (miss_inc[g]),
            .cnt_o   (miss_cnt[g]),
            .pulse_o (miss_pulse[g])
        );
    end

    logic ref_e, rsp_e, ovf_now;

    always_comb begin
        ref_e   = edg[CH_REF];
        rsp_e   = edg[CH_RSP];
        // A full counter lap has elapsed if the index has come back round.
        ovf_now = cur_q.wrap || (cur_q.idx == cur_q.ref_idx);

        nxt_d        = cur_q;
        nxt_d.primed = 1'b1;
        nxt_d.idx    = cur_q.idx + CNT_W'(1);
        nxt_d.vld    = 1'b0;
        miss_inc     = '0;

        unique case (cur_q.st)
            ST_WAIT_REF: begin
                if (ref_e) begin
                    nxt_d.ref_idx = cur_q.idx;
                    nxt_d.wrap    = 1'b0;
                    if (rsp_e) begin
                        // Both steps in one sample: zero-length pairing.
                        nxt_d.delta    = '0;
                        nxt_d.ovf      = 1'b0;
                        nxt_d.vld      = 1'b1;
                        nxt_d.have_rsp = 1'b1;
                        nxt_d.st       = ST_WAIT_REF;
                    end else begin
                        nxt_d.st = ST_WAIT_RSP;
                    end
                end else if (rsp_e && cur_q.have_rsp) begin
                    miss_inc[CH_RSP] = 1'b1;
                end
            end
            ST_WAIT_RSP: begin
                if (rsp_e) begin
                    nxt_d.delta    = cur_q.idx - cur_q.ref_idx;
                    nxt_d.ovf      = ovf_now;
                    nxt_d.vld      = 1'b1;
                    nxt_d.have_rsp = 1'b1;
                    if (ref_e) begin
                        nxt_d.ref_idx = cur_q.idx;
                        nxt_d.wrap    = 1'b0;
                        nxt_d.st      = ST_WAIT_RSP;
                    end else begin
                        nxt_d.st = ST_WAIT_REF;
                    end
                end else begin
                    if (ref_e) begin
                        miss_inc[CH_REF] = 1'b1;
                    end
                    if (cur_q.idx == cur_q.ref_idx) begin
                        nxt_d.wrap = 1'b1;
                    end
                end
            end
            default: nxt_d.st = ST_WAIT_REF;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q <= '{st: ST_WAIT_REF, default: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign delta_o          = cur_q.delta;
    assign delta_valid_o    = cur_q.vld;
    assign delta_ovf_o      = cur_q.ovf;
    assign miss_ref_pulse_o = miss_pulse[CH_REF];
    assign miss_rsp_pulse_o = miss_pulse[CH_RSP];
    assign miss_ref_cnt_o   = miss_cnt[CH_REF];
    assign miss_rsp_cnt_o   = miss_cnt[CH_RSP];

    // R12: a measurement and a miss event never share a cycle
    assert_valid_excl_miss_R12: assert property (
        @(posedge clk_i) disable iff (rst_i)
        delta_valid_o |-> !(miss_ref_pulse_o || miss_rsp_pulse_o)
    );

    // R11: the result holds while no new measurement is strobed
    assert_delta_hold_R11: assert property (
        @(posedge clk_i) disable iff (rst_i)
        !delta_valid_o |-> ($stable(delta_o) && $stable(delta_ovf_o))
    );

    // R7: no missed response can be booked before a first measurement
    assert_no_early_miss_R7: assert property (
        @(posedge clk_i) disable iff (rst_i)
        (miss_rsp_pulse_o && !$past(miss_rsp_pulse_o)) |-> cur_q.have_rsp
    );

    // R6: a missed reference leaves the machine waiting for a response
    assert_miss_keeps_wait_R6: assert property (
        @(posedge clk_i) disable iff (rst_i)
        miss_ref_pulse_o |-> (cur_q.st == ST_WAIT_RSP)
    );

endmodule

// File: tb/skew_meter_tb_top.sv
module skew_meter_tb_top;

    localparam int CW = 12;
    localparam int MW = 4;
    localparam longint SPAN = 64'd1 << CW;
    localparam int MMAX = (1 << MW) - 1;

    logic          clk_i = 1'b0;
    logic          rst_i = 1'b1;
    logic          ref_i = 1'b0;
    logic          rsp_i = 1'b0;
    logic [1:0]    ref_pol_i = 2'd0;
    logic [1:0]    rsp_pol_i = 2'd0;
    logic [CW-1:0] delta_o;
    logic          delta_valid_o;
    logic          delta_ovf_o;
    logic          miss_ref_pulse_o;
    logic          miss_rsp_pulse_o;
    logic [MW-1:0] miss_ref_cnt_o;
    logic [MW-1:0] miss_rsp_cnt_o;

    skew_meter #(.CNT_W(CW), .MISS_W(MW)) dut_i (
        .clk_i            (clk_i),
        .rst_i            (rst_i),
        .ref_i            (ref_i),
        .rsp_i            (rsp_i),
        .ref_pol_i        (ref_pol_i),
        .rsp_pol_i        (rsp_pol_i),
        .delta_o          (delta_o),
        .delta_valid_o    (delta_valid_o),
        .delta_ovf_o      (delta_ovf_o),
        .miss_ref_pulse_o (miss_ref_pulse_o),
        .miss_rsp_pulse_o (miss_rsp_pulse_o),
        .miss_ref_cnt_o   (miss_ref_cnt_o),
        .miss_rsp_cnt_o   (miss_rsp_cnt_o)
    );

    always #2 clk_i = ~clk_i;

    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string scen   = "R1";

    // reference model state
    bit     m_primed, m_pref, m_prsp, m_wait_rsp, m_have;
    longint m_idx, m_ref, m_delta;
    bit     m_vld, m_ovf, m_pr, m_ps;
    int     m_cr, m_cs;

    function automatic bit qual(bit prev, bit cur, logic [1:0] p);
        if (p == 2'd0) return !prev && cur;
        if (p == 2'd1) return prev && !cur;
        return prev != cur;
    endfunction

    function automatic int sat_inc(int v);
        return (v >= MMAX) ? MMAX : v + 1;
    endfunction

    function automatic void model_reset();
        m_primed = 0; m_pref = 0; m_prsp = 0; m_wait_rsp = 0; m_have = 0;
        m_idx = 0; m_ref = 0; m_delta = 0;
        m_vld = 0; m_ovf = 0; m_pr = 0; m_ps = 0; m_cr = 0; m_cs = 0;
    endfunction

    function automatic void record(longint iv);
        m_delta = iv % SPAN;
        m_ovf   = (iv >= SPAN);
        m_vld   = 1;
        m_have  = 1;
    endfunction

    function automatic void model_step(bit r, bit s);
        bit re, se;
        re = m_primed && qual(m_pref, r, ref_pol_i);
        se = m_primed && qual(m_prsp, s, rsp_pol_i);
        m_vld = 0; m_pr = 0; m_ps = 0;
        if (!m_wait_rsp) begin
            if (re) begin
                m_ref = m_idx;
                if (se) record(0);
                else    m_wait_rsp = 1;
            end else if (se && m_have) begin
                m_cs = sat_inc(m_cs); m_ps = 1;
            end
        end else begin
            if (se) begin
                record(m_idx - m_ref);
                if (re) m_ref = m_idx;
                else    m_wait_rsp = 0;
            end else if (re) begin
                m_cr = sat_inc(m_cr); m_pr = 1;
            end
        end
        m_pref = r; m_prsp = s; m_primed = 1; m_idx++;
    endfunction

    task automatic chk(string req, string name, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, scen, name, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(m_vld ? "R4" : "R11", "delta_o", longint'(delta_o), m_delta);
        chk("R4", "delta_valid_o", longint'(delta_valid_o), longint'(m_vld));
        chk("R10", "delta_ovf_o", longint'(delta_ovf_o), longint'(m_ovf));
        chk("R6", "miss_ref_pulse_o", longint'(miss_ref_pulse_o), longint'(m_pr));
        chk("R7", "miss_rsp_pulse_o", longint'(miss_rsp_pulse_o), longint'(m_ps));
        chk("R9", "miss_ref_cnt_o", longint'(miss_ref_cnt_o), longint'(m_cr));
        chk("R9", "miss_rsp_cnt_o", longint'(miss_rsp_cnt_o), longint'(m_cs));
        chk("R12", "valid_and_miss", longint'(delta_valid_o && (miss_ref_pulse_o || miss_rsp_pulse_o)), 0);
    endtask

    // Drive one sample at the falling edge, check after the next rising edge.
    task automatic tick(bit r, bit s);
        ref_i = r; rsp_i = s;
        model_step(r, s);
        @(posedge clk_i);
        @(negedge clk_i);
        compare_all();
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        model_reset();
        scen = "R1";
        compare_all();
        rst_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk_i);
        ref_i = 1'b1;  // held high through reset for the priming case
        do_reset();

        // R3: input high at the first sample is not a rising edge
        scen = "R3";
        tick(1, 1); tick(1, 1); tick(0, 0);
        chk("R3", "no_result_after_prime", longint'(delta_valid_o), 0);

        // R4: plain pairing, response four samples after reference
        scen = "R4";
        tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 1);
        chk("R4", "delta_direct", longint'(delta_o), 4);
        tick(0, 0); tick(0, 0);

        // R7: response edges with no reference pending
        scen = "R7";
        tick(0, 1); tick(0, 0); tick(0, 1); tick(0, 0);
        chk("R7", "miss_rsp_count", longint'(miss_rsp_cnt_o), 2);

        // R5: coincident edges while waiting for a reference
        scen = "R5";
        tick(1, 1);
        chk("R5", "zero_delta", longint'(delta_o), 0);
        tick(0, 0);

        // R6: second reference before the response
        scen = "R6";
        tick(1, 0); tick(0, 0); tick(1, 0); tick(1, 1);
        chk("R6", "delta_from_first_ref", longint'(delta_o), 3);
        tick(0, 0);

        // R8: response and new reference together while waiting for a response
        scen = "R8";
        tick(1, 0); tick(0, 0); tick(1, 1); tick(1, 0); tick(1, 0);
        tick(0, 0);
        tick(0, 1);
        chk("R8", "delta_after_relatch", longint'(delta_o), 4);

        // R2: falling reference, either-edge response
        scen = "R2";
        ref_pol_i = 2'd1; rsp_pol_i = 2'd3;
        tick(1, 1); tick(0, 1); tick(0, 1); tick(0, 0);
        chk("R2", "fall_to_any", longint'(delta_o), 2);
        ref_pol_i = 2'd2; rsp_pol_i = 2'd1;
        tick(1, 1); tick(1, 0);
        chk("R2", "any_to_fall", longint'(delta_o), 1);
        ref_pol_i = 2'd0; rsp_pol_i = 2'd0;
        tick(0, 0);

        // R9: saturate the missed-reference counter
        scen = "R9";
        tick(1, 0);
        for (int i = 0; i < 20; i++) begin
            tick(0, 0); tick(1, 0);
        end
        chk("R9", "miss_ref_saturated", longint'(miss_ref_cnt_o), MMAX);
        tick(1, 1); tick(0, 0);

        // R10: interval of exactly one counter lap, then a little more
        scen = "R10";
        tick(1, 0);
        for (int i = 0; i < (1 << CW) - 1; i++) tick(1, 0);
        tick(1, 1);
        chk("R10", "ovf_at_lap", longint'(delta_ovf_o), 1);
        tick(0, 0);
        tick(1, 0);
        for (int i = 0; i < (1 << CW) + 3; i++) tick(1, 0);
        tick(1, 1);
        chk("R10", "ovf_past_lap", longint'(delta_ovf_o), 1);
        tick(0, 0); tick(1, 0);
        for (int i = 0; i < (1 << CW) - 2; i++) tick(1, 0);
        tick(1, 1);
        chk("R10", "no_ovf_below_lap", longint'(delta_ovf_o), 0);

        // R1: reset mid-run with state pending, then random traffic
        tick(0, 0); tick(1, 0);
        do_reset();
        scen = "R12";
        for (int i = 0; i < 30000; i++) begin
            if (($urandom % 500) == 0) begin
                ref_pol_i = 2'($urandom);
                rsp_pol_i = 2'($urandom);
            end
            tick(($urandom % 4) == 0 ? ~ref_i : ref_i,
                 ($urandom % 5) == 0 ? ~rsp_i : rsp_i);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog [%s] run did not complete actual=1 expected=0", scen);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule